// File: doc/BRIEF.md
# Write-Through Store Pipeline with Direct-Mapped Tag Check

This block takes CPU store accesses for a write-through cache and runs each one through three stages. In the first stage the store address drives the cache address bus and is checked against the tag and valid bit of the line it indexes. In the second stage the store data and byte strobes drive the cache data bus. If the check matched, the strobed bytes are merged into the cached word at the end of that cycle. In the same cycle the address goes out on the internal address bus. In the third stage the data and strobes go out on the internal data bus and wait for the external ready.

Every store is forwarded to memory whether it hits or misses. A miss never allocates a line. A write hit changes neither tag nor valid bit. The CPU sees a stall only when all three stages are occupied and the external write in the last stage has not been acknowledged. Back-to-back stores therefore overlap: the next address can be on the cache address bus while the previous store's data is on the cache data bus and its address is on the internal address bus.

Lines are made resident through a one-word install port. The install writes the tag, sets the valid bit and stores one word. A registered lookup port returns the hit flag and the word for any address.

Each of the first two stages is a two-state controller with states STG_EMPTY and STG_FULL:
- load: STG_EMPTY to STG_FULL.
- drain: STG_FULL to STG_EMPTY, when the content moves on and nothing replaces it.
- refill: STG_FULL to STG_FULL, when the content moves on and a new store arrives in the same cycle.
- hold: STG_FULL to STG_FULL, when the content cannot move on.

The external data phase is a controller with states XS_IDLE and XS_WAIT:
- issue: XS_IDLE to XS_WAIT, when a store enters the data phase.
- retire: XS_WAIT to XS_IDLE, when ready is seen and no store follows.
- chain: XS_WAIT to XS_WAIT, when ready is seen and the next store enters.
- wait: XS_WAIT to XS_WAIT, while ready is low.

Top module: `wt_store_path`

## Requirements
- R1: After reset all stage outputs (`cab_valid`, `cdb_valid`, `ib_addr_valid`, `ib_data_valid`) are low, `cpu_stall` is low while no store is offered, and every line is invalid, so a lookup returns `rd_hit` = 0.
- R2: A store offered with `cpu_st_valid` high and `cpu_stall` low at a rising edge is accepted there. In the next cycle `cab_valid` is high and `cab_addr` equals its address. Without an acceptance and with the address stage free to move on, `cab_valid` is low.
- R3: When the address stage moves on, in the following cycle `cdb_valid` is high and `cdb_data`/`cdb_be` carry that store's data and strobes. In that same cycle `ib_addr_valid` is high and `ib_addr` equals the address that was on `cab_addr` one cycle earlier.
- R4: When the data stage moves on, in the following cycle `ib_data_valid` is high and `ib_data`/`ib_be` equal the previous cycle's `cdb_data`/`cdb_be`. While `ib_ready` is low they stay unchanged.
- R5: Every accepted store, hit or miss, completes exactly once on the internal data bus (`ib_data_valid` and `ib_ready` both high at an edge), in acceptance order, with its own data and strobes.
- R6: A store hits when the indexed line is valid and its tag equals the address tag. Address fields are: bits [1:0] byte, bits [3:2] word in line, bits [9:4] line index, bits [31:10] tag. `cdb_hit` shows the result. On a hit, each byte whose `cpu_st_be` bit is set (bit k covers data bits 8k+7..8k) replaces the stored byte, and the other bytes are kept.
- R7: On a miss the data array is left unchanged and no line is allocated: a later lookup at the missed address still returns `rd_hit` = 0 if its line was invalid or held another tag.
- R8: `cpu_stall` is high exactly when `cpu_st_valid`, `cab_valid`, `cdb_valid` and `ib_data_valid` are high and `ib_ready` is low. The CPU holds its store inputs while stalled.
- R9: Store hits leave the tag and valid bit of the line unchanged, so a later lookup with the same address still hits.
- R10: An install (`inst_valid` high at an edge) sets the valid bit and tag of the line indexed by `inst_addr` and writes `inst_data` to the word it selects.
- R11: A lookup presents `rd_hit` and `rd_data` for `rd_addr` one cycle after the edge that samples it.
- R12: While a stage holds because the stage after it is blocked, its bus outputs stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cpu_st_valid | input | 1 | CPU offers a store |
| cpu_st_addr | input | 32 | Store byte address |
| cpu_st_data | input | 32 | Store data |
| cpu_st_be | input | 4 | Store byte strobes |
| cpu_stall | output | 1 | Store cannot be accepted this cycle |
| cab_valid | output | 1 | Cache address bus carries a store |
| cab_addr | output | 32 | Cache address bus |
| cdb_valid | output | 1 | Cache data bus carries a store |
| cdb_data | output | 32 | Cache data bus |
| cdb_be | output | 4 | Strobes on the cache data bus |
| cdb_hit | output | 1 | Store on the cache data bus hit |
| ib_addr_valid | output | 1 | Internal address bus carries a store |
| ib_addr | output | 32 | Internal address bus |
| ib_data_valid | output | 1 | Internal data phase pending |
| ib_data | output | 32 | Internal data bus |
| ib_be | output | 4 | Strobes on the internal data bus |
| ib_ready | input | 1 | External side takes the data phase |
| inst_valid | input | 1 | Install a word and make its line resident |
| inst_addr | input | 32 | Install address |
| inst_data | input | 32 | Install word |
| rd_addr | input | 32 | Lookup address |
| rd_hit | output | 1 | Lookup hit, one cycle later |
| rd_data | output | 32 | Looked-up word, one cycle later |

## Verification
Acceptance shows on the cache address bus one cycle after the accepting edge. Cache data and internal address follow one cycle after the address stage moves on. Internal data follows one cycle after the data stage moves on. The bench keeps a snapshot of the ports and of `ib_ready` from the previous cycle and decides from it which of move-on, hold or idle applies. It samples every result at the falling edge after the rising edge where it is due. Lookup results are read two falling edges after the address is driven. Completions are scored in the same cycle in which ready and data-valid are both seen, against a queue kept in acceptance order.

// File: rtl/wt_pkg.sv
`timescale 1ns/1ps
package wt_pkg;
    typedef enum logic {
        STG_EMPTY = 1'b0,
        STG_FULL  = 1'b1
    } stage_state_t;

    typedef enum logic {
        XS_IDLE = 1'b0,
        XS_WAIT = 1'b1
    } ext_state_t;
endpackage

// File: rtl/wt_stage_ctl.sv
`timescale 1ns/1ps
module wt_stage_ctl
    import wt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic take,
    output logic full
);
    stage_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= STG_EMPTY;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            STG_EMPTY: if (load) state_d = STG_FULL;
            STG_FULL:  if (take && !load) state_d = STG_EMPTY;
        endcase
    end

    always_comb begin
        full = (state_q == STG_FULL);
    end

    // R12: a full stage that is not drained must not be overwritten
    p_no_overwrite_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !take) |-> !load);
endmodule

// File: rtl/wt_tag_store.sv
`timescale 1ns/1ps
module wt_tag_store #(
    parameter int TAG_W = 22,
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] lk_idx,
    input  logic [TAG_W-1:0] lk_tag,
    output logic             lk_hit,
    input  logic [IDX_W-1:0] rd_idx,
    input  logic [TAG_W-1:0] rd_tag,
    output logic             rd_hit,
    input  logic             inst_en,
    input  logic [IDX_W-1:0] inst_idx,
    input  logic [TAG_W-1:0] inst_tag
);
    localparam int LINES = 1 << IDX_W;

    logic [LINES-1:0] valid_q;
    logic [TAG_W-1:0] tag_q [LINES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= '0;
            for (int i = 0; i < LINES; i++) tag_q[i] <= '0;
        end else if (inst_en) begin
            valid_q[inst_idx] <= 1'b1;
            tag_q[inst_idx]   <= inst_tag;
        end
    end

    always_comb begin
        lk_hit = valid_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
        rd_hit = valid_q[rd_idx] && (tag_q[rd_idx] == rd_tag);
    end

    // R10: an install makes the line resident with the given tag
    p_install_resident_r10: assert property (@(posedge clk) disable iff (!rst_n)
        inst_en |=> (valid_q[$past(inst_idx)] && tag_q[$past(inst_idx)] == $past(inst_tag)));
endmodule

// File: rtl/wt_data_store.sv
`timescale 1ns/1ps
module wt_data_store #(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 6,
    parameter int WSEL_W = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [IDX_W-1:0]    wr_idx,
    input  logic [WSEL_W-1:0]   wr_wsel,
    input  logic [DATA_W/8-1:0] wr_be,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic                inst_en,
    input  logic [IDX_W-1:0]    inst_idx,
    input  logic [WSEL_W-1:0]   inst_wsel,
    input  logic [DATA_W-1:0]   inst_data,
    input  logic [IDX_W-1:0]    rd_idx,
    input  logic [WSEL_W-1:0]   rd_wsel,
    output logic [DATA_W-1:0]   rd_data
);
    localparam int LANES  = DATA_W / 8;
    localparam int NWORDS = 1 << (IDX_W + WSEL_W);

    logic [DATA_W-1:0] mem_q [NWORDS];
    logic [IDX_W+WSEL_W-1:0] wr_word, inst_word, rd_word;

    always_comb begin
        wr_word   = {wr_idx, wr_wsel};
        inst_word = {inst_idx, inst_wsel};
        rd_word   = {rd_idx, rd_wsel};
        rd_data   = mem_q[rd_word];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NWORDS; i++) mem_q[i] <= '0;
        end else begin
            if (wr_en) begin
                for (int b = 0; b < LANES; b++) begin
                    if (wr_be[b]) mem_q[wr_word][b*8 +: 8] <= wr_data[b*8 +: 8];
                end
            end
            if (inst_en) mem_q[inst_word] <= inst_data;
        end
    end

    // R6: strobed lanes of a store hit land in the array
    generate
        for (genvar g = 0; g < LANES; g++) begin : g_lane_chk
            p_lane_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_en && wr_be[g] && !inst_en) |=>
                    (mem_q[$past(wr_word)][g*8 +: 8] == $past(wr_data[g*8 +: 8])));
        end
    endgenerate
endmodule

// File: rtl/wt_ext_fsm.sv
`timescale 1ns/1ps
module wt_ext_fsm
    import wt_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic [DATA_W-1:0]   ld_data,
    input  logic [DATA_W/8-1:0] ld_be,
    input  logic                ib_ready,
    output logic                free,
    output logic                ib_data_valid,
    output logic [DATA_W-1:0]   ib_data,
    output logic [DATA_W/8-1:0] ib_be
);
    ext_state_t state_q, state_d;
    logic [DATA_W-1:0]   data_q;
    logic [DATA_W/8-1:0] be_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= XS_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
            be_q   <= '0;
        end else if (load) begin
            data_q <= ld_data;
            be_q   <= ld_be;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            XS_IDLE: if (load) state_d = XS_WAIT;
            XS_WAIT: if (ib_ready && !load) state_d = XS_IDLE;
        endcase
    end

    always_comb begin
        ib_data_valid = (state_q == XS_WAIT);
        free          = (state_q == XS_IDLE) || ib_ready;
        ib_data       = data_q;
        ib_be         = be_q;
    end

    // R4: an unacknowledged data phase is held unchanged
    p_data_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ib_data_valid && !ib_ready) |=> (ib_data_valid && $stable(ib_data) && $stable(ib_be)));
    // R5: a pending write is never dropped without ready
    p_no_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ib_data_valid && !ib_ready) |-> !load);
endmodule

// File: rtl/wt_store_path.sv
`timescale 1ns/1ps
module wt_store_path #(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int LINE_BYTES = 16,
    parameter int LINES      = 64
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cpu_st_valid,
    input  logic [ADDR_W-1:0]   cpu_st_addr,
    input  logic [DATA_W-1:0]   cpu_st_data,
    input  logic [DATA_W/8-1:0] cpu_st_be,
    output logic                cpu_stall,
    output logic                cab_valid,
    output logic [ADDR_W-1:0]   cab_addr,
    output logic                cdb_valid,
    output logic [DATA_W-1:0]   cdb_data,
    output logic [DATA_W/8-1:0] cdb_be,
    output logic                cdb_hit,
    output logic                ib_addr_valid,
    output logic [ADDR_W-1:0]   ib_addr,
    output logic                ib_data_valid,
    output logic [DATA_W-1:0]   ib_data,
    output logic [DATA_W/8-1:0] ib_be,
    input  logic                ib_ready,
    input  logic                inst_valid,
    input  logic [ADDR_W-1:0]   inst_addr,
    input  logic [DATA_W-1:0]   inst_data,
    input  logic [ADDR_W-1:0]   rd_addr,
    output logic                rd_hit,
    output logic [DATA_W-1:0]   rd_data
);
    localparam int BE_W     = DATA_W / 8;
    localparam int BOFF_W   = $clog2(BE_W);
    localparam int WORDS    = LINE_BYTES / BE_W;
    localparam int WSEL_W   = $clog2(WORDS);
    localparam int OFF_W    = $clog2(LINE_BYTES);
    localparam int IDX_W    = $clog2(LINES);
    localparam int TAG_W    = ADDR_W - IDX_W - OFF_W;

    // address stage payload
    logic              s1_full, s1_adv, s1_room;
    logic [ADDR_W-1:0] s1_addr;
    logic [DATA_W-1:0] s1_data;
    logic [BE_W-1:0]   s1_be;
    // data stage payload
    logic              s2_full, s2_adv, s2_room;
    logic [ADDR_W-1:0] s2_addr;
    logic [DATA_W-1:0] s2_data;
    logic [BE_W-1:0]   s2_be;
    logic              s2_hit;

    logic accept, ext_free, lk_hit, dwr_en;
    logic tag_rd_hit;
    logic [DATA_W-1:0] arr_rd_data;
    logic unused_low_bits;

    // ---------------- flow control ----------------
    always_comb begin
        s2_adv    = s2_full && ext_free;
        s2_room   = !s2_full || ext_free;
        s1_adv    = s1_full && s2_room;
        s1_room   = !s1_full || s2_room;
        accept    = cpu_st_valid && s1_room;
        cpu_stall = cpu_st_valid && !s1_room;
        dwr_en    = s2_adv && s2_hit;
    end

    wt_stage_ctl u_addr_stage (
        .clk  (clk),
        .rst_n(rst_n),
        .load (accept),
        .take (s1_adv),
        .full (s1_full)
    );

    wt_stage_ctl u_data_stage (
        .clk  (clk),
        .rst_n(rst_n),
        .load (s1_adv),
        .take (s2_adv),
        .full (s2_full)
    );

    // ---------------- payload registers ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_addr <= '0;
            s1_data <= '0;
            s1_be   <= '0;
        end else if (accept) begin
            s1_addr <= cpu_st_addr;
            s1_data <= cpu_st_data;
            s1_be   <= cpu_st_be;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s2_addr <= '0;
            s2_data <= '0;
            s2_be   <= '0;
            s2_hit  <= 1'b0;
        end else if (s1_adv) begin
            s2_addr <= s1_addr;
            s2_data <= s1_data;
            s2_be   <= s1_be;
            s2_hit  <= lk_hit;
        end
    end

    // ---------------- arrays ----------------
    wt_tag_store #(
        .TAG_W(TAG_W),
        .IDX_W(IDX_W)
    ) u_tags (
        .clk     (clk),
        .rst_n   (rst_n),
        .lk_idx  (s1_addr[OFF_W +: IDX_W]),
        .lk_tag  (s1_addr[ADDR_W-1 -: TAG_W]),
        .lk_hit  (lk_hit),
        .rd_idx  (rd_addr[OFF_W +: IDX_W]),
        .rd_tag  (rd_addr[ADDR_W-1 -: TAG_W]),
        .rd_hit  (tag_rd_hit),
        .inst_en (inst_valid),
        .inst_idx(inst_addr[OFF_W +: IDX_W]),
        .inst_tag(inst_addr[ADDR_W-1 -: TAG_W])
    );

    wt_data_store #(
        .DATA_W(DATA_W),
        .IDX_W (IDX_W),
        .WSEL_W(WSEL_W)
    ) u_data (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (dwr_en),
        .wr_idx   (s2_addr[OFF_W +: IDX_W]),
        .wr_wsel  (s2_addr[BOFF_W +: WSEL_W]),
        .wr_be    (s2_be),
        .wr_data  (s2_data),
        .inst_en  (inst_valid),
        .inst_idx (inst_addr[OFF_W +: IDX_W]),
        .inst_wsel(inst_addr[BOFF_W +: WSEL_W]),
        .inst_data(inst_data),
        .rd_idx   (rd_addr[OFF_W +: IDX_W]),
        .rd_wsel  (rd_addr[BOFF_W +: WSEL_W]),
        .rd_data  (arr_rd_data)
    );

    // ---------------- external data phase ----------------
    wt_ext_fsm #(
        .DATA_W(DATA_W)
    ) u_ext (
        .clk          (clk),
        .rst_n        (rst_n),
        .load         (s2_adv),
        .ld_data      (s2_data),
        .ld_be        (s2_be),
        .ib_ready     (ib_ready),
        .free         (ext_free),
        .ib_data_valid(ib_data_valid),
        .ib_data      (ib_data),
        .ib_be        (ib_be)
    );

    // ---------------- lookup port ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_hit  <= 1'b0;
            rd_data <= '0;
        end else begin
            rd_hit  <= tag_rd_hit;
            rd_data <= arr_rd_data;
        end
    end

    // ---------------- bus outputs ----------------
    always_comb begin
        cab_valid     = s1_full;
        cab_addr      = s1_addr;
        cdb_valid     = s2_full;
        cdb_data      = s2_data;
        cdb_be        = s2_be;
        cdb_hit       = s2_hit;
        ib_addr_valid = s2_full;
        ib_addr       = s2_addr;
    end

    assign unused_low_bits = ^{inst_addr[BOFF_W-1:0], rd_addr[BOFF_W-1:0]};

    // ---------------- assertions ----------------
    p_accept_to_cab_r2: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (cab_valid && cab_addr == $past(cpu_st_addr)));
    p_cab_to_ib_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        s1_adv |=> (ib_addr_valid && cdb_valid && ib_addr == $past(cab_addr)));
    p_cdb_to_ib_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
        s2_adv |=> (ib_data_valid && ib_data == $past(cdb_data) && ib_be == $past(cdb_be)));
    p_miss_no_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cdb_valid && !cdb_hit) |-> !dwr_en);
    p_stall_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_stall |-> (cab_valid && cdb_valid && ib_data_valid && !ib_ready));
    p_cab_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (cab_valid && !s1_adv) |=> (cab_valid && $stable(cab_addr)));
endmodule

// File: tb/wt_store_path_bench.sv
`timescale 1ns/1ps
module wt_store_path_bench;
    localparam int AW = 32, DW = 32, LB = 16, NL = 64;
    localparam int TW = 22, NW = 4;

    typedef struct packed {
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
        logic [3:0]    be;
        logic          hit;
    } st_t;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cpu_st_valid = 0; logic [AW-1:0] cpu_st_addr = '0; logic [DW-1:0] cpu_st_data = '0;
    logic [3:0] cpu_st_be = '0; logic cpu_stall;
    logic cab_valid, cdb_valid, cdb_hit, ib_addr_valid, ib_data_valid;
    logic [AW-1:0] cab_addr, ib_addr; logic [DW-1:0] cdb_data, ib_data;
    logic [3:0] cdb_be, ib_be;
    logic ib_ready = 0, inst_valid = 0; logic [AW-1:0] inst_addr = '0, rd_addr = '0;
    logic [DW-1:0] inst_data = '0; logic rd_hit; logic [DW-1:0] rd_data;

    wt_store_path u_wt_store_path (
        .clk(clk), .rst_n(rst_n), .cpu_st_valid(cpu_st_valid), .cpu_st_addr(cpu_st_addr),
        .cpu_st_data(cpu_st_data), .cpu_st_be(cpu_st_be), .cpu_stall(cpu_stall),
        .cab_valid(cab_valid), .cab_addr(cab_addr), .cdb_valid(cdb_valid), .cdb_data(cdb_data),
        .cdb_be(cdb_be), .cdb_hit(cdb_hit), .ib_addr_valid(ib_addr_valid), .ib_addr(ib_addr),
        .ib_data_valid(ib_data_valid), .ib_data(ib_data), .ib_be(ib_be), .ib_ready(ib_ready),
        .inst_valid(inst_valid), .inst_addr(inst_addr), .inst_data(inst_data),
        .rd_addr(rd_addr), .rd_hit(rd_hit), .rd_data(rd_data));

    always #2.5 clk = ~clk;

    int checks = 0, errors = 0;
    bit mv [NL]; logic [TW-1:0] mt [NL]; logic [DW-1:0] md [NL*NW];
    st_t q_cdb[$], q_ext[$];
    // next inputs
    logic n_valid = 0, n_ready = 0, n_inst = 0;
    logic [AW-1:0] n_addr = '0, n_iaddr = '0, n_raddr = '0;
    logic [DW-1:0] n_data = '0, n_idata = '0; logic [3:0] n_be = '0;
    // previous-cycle snapshot
    logic p_acc = 0, p_cab_v = 0, p_cdb_v = 0, p_ibd_v = 0, p_rdy = 0;
    logic [AW-1:0] p_acc_addr = '0, p_cab_addr = '0;
    logic [DW-1:0] p_cdb_data = '0, p_ib_data = '0; logic [3:0] p_cdb_be = '0, p_ib_be = '0;
    int completed = 0, accepted = 0;

    function automatic logic [AW-1:0] mk_addr(logic [TW-1:0] t, int idx, int w);
        return {t, idx[5:0], w[1:0], 2'b00};
    endfunction
    function automatic int widx(logic [AW-1:0] a);
        return int'(a[9:4]) * NW + int'(a[3:2]);
    endfunction
    function automatic logic model_hit(logic [AW-1:0] a);
        return mv[a[9:4]] && (mt[a[9:4]] == a[31:10]);
    endfunction
    function automatic logic [DW-1:0] merge(logic [DW-1:0] o, logic [DW-1:0] n, logic [3:0] be);
        logic [DW-1:0] r = o;
        for (int b = 0; b < 4; b++) if (be[b]) r[b*8 +: 8] = n[b*8 +: 8];
        return r;
    endfunction

    task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic monitor();
        logic adv2, adv1;
        st_t e;
        adv2 = !(p_ibd_v && !p_rdy);
        adv1 = !(p_cdb_v && !adv2);
        if (p_acc) chk(cab_valid && cab_addr == p_acc_addr, "R2", "cab after accept", cab_addr, p_acc_addr);
        else if (!p_cab_v || adv1) chk(!cab_valid, "R2", "cab idle", cab_valid, 0);
        else chk(cab_valid && cab_addr == p_cab_addr, "R12", "cab hold", cab_addr, p_cab_addr);
        if (p_cab_v && adv1) begin
            if (q_cdb.size() == 0) chk(0, "R3", "unexpected cdb store", cdb_data, 0);
            else begin
                e = q_cdb.pop_front();
                chk(cdb_valid && ib_addr_valid && ib_addr == p_cab_addr, "R3", "ib_addr lag", ib_addr, p_cab_addr);
                chk(cdb_data == e.data && cdb_be == e.be, "R3", "cdb payload", {cdb_be, cdb_data}, {e.be, e.data});
                chk(cdb_hit == e.hit, "R6", "cdb_hit", cdb_hit, e.hit);
                q_ext.push_back(e);
            end
        end else if (p_cdb_v && !adv2)
            chk(cdb_valid && cdb_data == p_cdb_data, "R12", "cdb hold", cdb_data, p_cdb_data);
        else chk(!cdb_valid && !ib_addr_valid, "R3", "cdb idle", cdb_valid, 0);
        if (p_cdb_v && adv2)
            chk(ib_data_valid && ib_data == p_cdb_data && ib_be == p_cdb_be, "R4", "ib_data lag",
                {ib_be, ib_data}, {p_cdb_be, p_cdb_data});
        else if (p_ibd_v && !p_rdy)
            chk(ib_data_valid && ib_data == p_ib_data && ib_be == p_ib_be, "R4", "ib hold", ib_data, p_ib_data);
        else chk(!ib_data_valid, "R4", "ib idle", ib_data_valid, 0);
    endtask

    task automatic predict();
        st_t e;
        logic es;
        es = cpu_st_valid && cab_valid && cdb_valid && ib_data_valid && !ib_ready;
        chk(cpu_stall == es, "R8", "stall", cpu_stall, es);
        if (ib_data_valid && ib_ready) begin
            if (q_ext.size() == 0) chk(0, "R5", "unexpected completion", ib_data, 0);
            else begin
                e = q_ext.pop_front();
                chk(ib_data == e.data && ib_be == e.be, "R5", "completion", {ib_be, ib_data}, {e.be, e.data});
                completed++;
            end
        end
        p_acc = cpu_st_valid && !cpu_stall;
        p_acc_addr = cpu_st_addr;
        if (p_acc) begin
            e.addr = cpu_st_addr; e.data = cpu_st_data; e.be = cpu_st_be; e.hit = model_hit(cpu_st_addr);
            if (e.hit) md[widx(cpu_st_addr)] = merge(md[widx(cpu_st_addr)], cpu_st_data, cpu_st_be);
            q_cdb.push_back(e);
            accepted++;
        end
        p_cab_v = cab_valid; p_cab_addr = cab_addr; p_cdb_v = cdb_valid; p_cdb_data = cdb_data;
        p_cdb_be = cdb_be; p_ibd_v = ib_data_valid; p_ib_data = ib_data; p_ib_be = ib_be; p_rdy = ib_ready;
    endtask

    task automatic step();
        @(negedge clk);
        monitor();
        cpu_st_valid = n_valid; cpu_st_addr = n_addr; cpu_st_data = n_data; cpu_st_be = n_be;
        ib_ready = n_ready; inst_valid = n_inst; inst_addr = n_iaddr; inst_data = n_idata; rd_addr = n_raddr;
        #1;
        predict();
    endtask

    task automatic put_store(logic [AW-1:0] a, logic [DW-1:0] d, logic [3:0] be);
        n_valid = 1; n_addr = a; n_data = d; n_be = be;
        step();
        while (!p_acc) step();
        n_valid = 0;
    endtask

    task automatic install(logic [AW-1:0] a, logic [DW-1:0] d);
        n_inst = 1; n_iaddr = a; n_idata = d;
        step();
        n_inst = 0;
        mv[a[9:4]] = 1; mt[a[9:4]] = a[31:10]; md[widx(a)] = d;
    endtask

    task automatic drain();
        n_valid = 0; n_ready = 1;
        for (int i = 0; i < 20; i++) step();
        chk(q_cdb.size() == 0 && q_ext.size() == 0 && completed == accepted, "R5", "all stores done",
            completed, accepted);
    endtask

    task automatic rd_chk(logic [AW-1:0] a, string req);
        logic eh;
        n_raddr = a;
        step(); step();
        eh = model_hit(a);
        chk(rd_hit == eh, req, "lookup hit", rd_hit, eh);
        if (eh) chk(rd_data == md[widx(a)], req, "lookup data", rd_data, md[widx(a)]);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [AW-1:0] a0;
        void'($urandom(32'h0C0FFEE5));
        for (int i = 0; i < NL; i++) begin mv[i] = 0; mt[i] = '0; end
        for (int i = 0; i < NL*NW; i++) md[i] = '0;
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(!cab_valid && !cdb_valid && !ib_addr_valid && !ib_data_valid && !cpu_stall, "R1",
            "reset outputs", {cab_valid, cdb_valid, ib_data_valid, cpu_stall}, 0);
        rd_chk(mk_addr('0, 5, 0), "R1");
        // R10: install lines 0..15
        for (int l = 0; l < 16; l++)
            for (int w = 0; w < NW; w++)
                install(mk_addr(22'h2A5 ^ TW'(l), l, w), $urandom);
        rd_chk(mk_addr(22'h2A5 ^ 22'd3, 3, 2), "R10");
        rd_chk(mk_addr(22'h2A5 ^ 22'd7, 7, 1), "R11");
        // R2/R3/R4 single hit, ready high
        n_ready = 1;
        put_store(mk_addr(22'h2A5 ^ 22'd1, 1, 2), 32'hDEADBEEF, 4'hF);
        drain();
        rd_chk(mk_addr(22'h2A5 ^ 22'd1, 1, 2), "R6");
        // R6 partial strobes
        put_store(mk_addr(22'h2A5 ^ 22'd4, 4, 3), 32'h11223344, 4'b0101);
        drain();
        rd_chk(mk_addr(22'h2A5 ^ 22'd4, 4, 3), "R6");
        // R7 miss on tag mismatch, and on an invalid line
        a0 = mk_addr(22'h2A5 ^ 22'd2 ^ 22'h100, 2, 0);
        put_store(a0, 32'hCAFEF00D, 4'hF);
        put_store(mk_addr('0, 30, 1), 32'h0BADF00D, 4'hF);
        drain();
        rd_chk(a0, "R7");
        rd_chk(mk_addr('0, 30, 1), "R7");
        rd_chk(mk_addr(22'h2A5 ^ 22'd2, 2, 0), "R7");
        rd_chk(mk_addr(22'h2A5 ^ 22'd1, 1, 2), "R9");
        // R8 back-pressure: three enter, fourth stalls
        n_ready = 0;
        put_store(mk_addr(22'h2A5 ^ 22'd5, 5, 0), 32'hA0A0A0A0, 4'hF);
        put_store(mk_addr(22'h2A5 ^ 22'd5, 5, 1), 32'hB1B1B1B1, 4'h3);
        put_store(mk_addr(22'h2A5 ^ 22'd6, 6, 2), 32'hC2C2C2C2, 4'hC);
        n_valid = 1; n_addr = mk_addr(22'h2A5 ^ 22'd6, 6, 3); n_data = 32'hD3D3D3D3; n_be = 4'hF;
        step();
        chk(cpu_stall == 1, "R8", "fourth store stalls", cpu_stall, 1);
        for (int i = 0; i < 5; i++) step();
        chk(cpu_stall == 1, "R12", "still stalled", cpu_stall, 1);
        n_ready = 1;
        step();
        while (!p_acc) step();
        n_valid = 0;
        drain();
        // random phase
        for (int c = 0; c < 4000; c++) begin
            if (!(cpu_st_valid && !p_acc)) begin
                int l, w;
                logic [TW-1:0] t;
                l = int'($urandom % 20); w = int'($urandom % NW);
                t = mt[l] ^ (($urandom % 3 == 0) ? 22'h1 : 22'h0);
                n_valid = ($urandom % 4) != 0;
                n_addr = mk_addr(t, l, w); n_data = $urandom; n_be = 4'($urandom % 15 + 1);
            end
            n_ready = ($urandom % 10) < 7;
            step();
        end
        n_valid = 0;
        step();
        while (!p_acc && cpu_st_valid) step();
        drain();
        for (int l = 0; l < 20; l++)
            for (int w = 0; w < NW; w++) rd_chk(mk_addr(mt[l], l, w), l < 16 ? "R6" : "R7");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule